// File: doc/BRIEF.md
# Four-Channel SPI Master Channel Sequencer

This block keeps the per-channel register state of a four-channel SPI master. Each channel has a configuration word, three status flags, an enable bit, a transmit holding word and a receive word. Software reaches them through a 32-bit word register port. The block decides when a channel's queued transmit word may be exchanged. It launches the exchange on a shared request/acknowledge port, which carries the channel number, the transmit word and the bit count. When the exchange completes, the block stores the returned word and updates the status flags. From the same state it drives one transmit and one receive DMA request line per channel.

Three register accesses re-run the start decision for the channel they touch: a transmit write, a receive read, and enabling a channel that was off. The decision is taken in the clock cycle after the access. A serial engine, or a test stub, answers the exchange port. Serial clocking, chip-select timing and pad drivers sit outside this block.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset every channel reads config 0x060000, status 0x2 and control 0. No exchange is requested and every DMA request line is low.
- R2: Channel n occupies byte addresses 0x2C + 0x14*n onward. The words are config (+0), status (+4), control (+8), transmit (+12) and receive (+16). A config write keeps bits 22:0 only, so writing 0xFFFFFFFF reads back 0x7FFFFF.
- R3: Writes to a status word or to a receive word change nothing that can be read back.
- R4: A transmit write stores the word, clears status bit 1 (TX empty) and triggers a start decision.
- R5: The start decision stalls in two cases. The first is status bit 0 (RX full) set, config mode (bits 13:12) not 2 (transmit-only) and config bit 19 (turbo) clear. The second is status bit 1 set and mode not 1 (receive-only). Mode 0 is full duplex.
- R6: An exchange raises xfer_req with xfer_ch, xfer_txd and xfer_bits = config bits 11:7 plus one. These hold steady until xfer_ack. The xfer_rxd value present at the acknowledge becomes the channel's receive word.
- R7: A transfer that proceeds clears the transmit word and sets status bit 2 (end of transfer) and bit 1. It also sets bit 0 unless the mode is transmit-only.
- R8: While single_ch is high and config bit 20 (force) is clear, a transfer that proceeds places no request on the port. R7's flag updates still take place.
- R9: Writing 1 to control bit 0 of a disabled channel enables it and triggers a start decision. A disabled channel never starts.
- R10: A receive read returns the stored word, clears status bit 0 and triggers a start decision.
- R11: tx_dma_req[n] is high when the channel is enabled, config bit 14 is set, status bit 1 is set and the mode is not 1. rx_dma_req[n] is high when the channel is enabled, config bit 15 is set, status bit 0 is set and the mode is not 2.
- R12: One exchange is outstanding at a time. A channel's pending decision waits while the port is busy. When the port frees, the lowest-numbered waiting channel wins.
- R13: A decision triggered by an access at clock edge k acts at edge k+1. Read data is registered and is valid after the edge that samples bus_rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| single_ch | input | 1 | Module single-channel mode; suppresses exchanges of channels without force |
| xfer_req | output | 1 | Exchange request, held until acknowledged |
| xfer_ch | output | log2(NUM_CH) | Channel of the outstanding exchange |
| xfer_txd | output | DATA_W | Word to shift out |
| xfer_bits | output | BITS_W | Number of bits to exchange |
| xfer_ack | input | 1 | Exchange complete, one-cycle pulse |
| xfer_rxd | input | DATA_W | Word shifted in, valid with xfer_ack |
| tx_dma_req | output | NUM_CH | Per-channel transmit DMA request |
| rx_dma_req | output | NUM_CH | Per-channel receive DMA request |

## Verification
A write or read that triggers a decision is sampled at edge k, and xfer_req reflects that decision after edge k+1. The bench therefore checks that xfer_req is still low one half-cycle after the access and high one cycle later. The status flags, the receive word and the DMA lines move at the edge that samples xfer_ack; in the skip case of R8 they move at edge k+1. Every read is taken on the falling edge after its sampling edge, and is issued at least one full cycle after the event whose result it checks.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CONF_W = 23;
  localparam logic [CONF_W-1:0] CONF_RST = 23'h060000;

  // configuration field positions
  localparam int CB_WL_LO  = 7;
  localparam int CB_WL_HI  = 11;
  localparam int CB_MODE   = 12;
  localparam int CB_TXDMA  = 14;
  localparam int CB_RXDMA  = 15;
  localparam int CB_TURBO  = 19;
  localparam int CB_FORCE  = 20;

  // byte offsets inside one channel group
  localparam int OFS_CONF = 0;
  localparam int OFS_STAT = 4;
  localparam int OFS_CTRL = 8;
  localparam int OFS_TX   = 12;
  localparam int OFS_RX   = 16;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'd0,
    MODE_RX_ONLY = 2'd1,
    MODE_TX_ONLY = 2'd2,
    MODE_BAD     = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic eot;
    logic tx_empty;
    logic rx_full;
  } chan_stat_t;
endpackage

// File: rtl/spi_chan.sv
module spi_chan
  import spi_seq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BITS_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_conf,
  input  logic              wr_ctrl,
  input  logic              wr_tx,
  input  logic              rd_rx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              single_ch,
  input  logic              grant,
  input  logic              done,
  input  logic [DATA_W-1:0] rxd,
  output logic [CONF_W-1:0] conf_q,
  output chan_stat_t        stat_q,
  output logic              en_q,
  output logic [DATA_W-1:0] tx_q,
  output logic [DATA_W-1:0] rx_q,
  output logic              want,
  output logic [BITS_W-1:0] bits,
  output logic              tx_dma,
  output logic              rx_dma
);
  logic       trig_q;
  logic       busy_q;
  xfer_mode_e mode;
  logic       stall;
  logic       go;
  logic       skip;
  logic       finish;

  assign mode   = xfer_mode_e'(conf_q[CB_MODE+1:CB_MODE]);
  assign bits   = BITS_W'(conf_q[CB_WL_HI:CB_WL_LO]) + BITS_W'(1);
  assign stall  = (stat_q.rx_full && mode != MODE_TX_ONLY && !conf_q[CB_TURBO]) ||
                  (stat_q.tx_empty && mode != MODE_RX_ONLY);
  assign go     = trig_q && !busy_q && en_q && !stall;
  assign skip   = single_ch && !conf_q[CB_FORCE];
  assign want   = go && !skip;
  assign finish = (go && skip) || done;

  assign tx_dma = en_q && conf_q[CB_TXDMA] && stat_q.tx_empty && mode != MODE_RX_ONLY;
  assign rx_dma = en_q && conf_q[CB_RXDMA] && stat_q.rx_full  && mode != MODE_TX_ONLY;

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_q <= CONF_RST;
      stat_q <= '{eot: 1'b0, tx_empty: 1'b1, rx_full: 1'b0};
      en_q   <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      trig_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      // retire the pending decision unless it waits for the port
      if (trig_q && !busy_q && (!want || grant)) trig_q <= 1'b0;
      if (grant) busy_q <= 1'b1;
      if (done) begin
        busy_q <= 1'b0;
        rx_q   <= rxd;
      end
      if (finish) begin
        tx_q            <= '0;
        stat_q.eot      <= 1'b1;
        stat_q.tx_empty <= 1'b1;
        if (mode != MODE_TX_ONLY) stat_q.rx_full <= 1'b1;
      end
      // register accesses take precedence over completion updates
      if (wr_conf) conf_q <= wdata[CONF_W-1:0];
      if (wr_ctrl) begin
        if (wdata[0] && !en_q) begin
          en_q   <= 1'b1;
          trig_q <= 1'b1;
        end else begin
          en_q <= wdata[0];
        end
      end
      if (wr_tx) begin
        tx_q            <= wdata;
        stat_q.tx_empty <= 1'b0;
        trig_q          <= 1'b1;
      end
      if (rd_rx) begin
        stat_q.rx_full <= 1'b0;
        trig_q         <= 1'b1;
      end
    end
  end

  p_tx_write_clears_r4: assert property (@(posedge clk) disable iff (rst)
    wr_tx |=> !stat_q.tx_empty);
  p_rx_read_clears_r10: assert property (@(posedge clk) disable iff (rst)
    rd_rx |=> !stat_q.rx_full);
  p_done_when_busy_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> busy_q);
  p_grant_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    grant |-> en_q && !busy_q);
endmodule

// File: rtl/spi_xfer_arb.sv
module spi_xfer_arb #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 32,
  parameter int BITS_W = 6,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CH-1:0]              want,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  tx_arr,
  input  logic [NUM_CH-1:0][BITS_W-1:0]  bits_arr,
  input  logic                           xfer_ack,
  output logic [NUM_CH-1:0]              grant,
  output logic [NUM_CH-1:0]              done,
  output logic                           xfer_req,
  output logic [CH_W-1:0]                xfer_ch,
  output logic [DATA_W-1:0]              xfer_txd,
  output logic [BITS_W-1:0]              xfer_bits
);
  logic [CH_W-1:0] sel;

  always_comb begin
    grant = '0;
    sel   = '0;
    if (!xfer_req) begin
      for (int i = NUM_CH - 1; i >= 0; i--) begin
        if (want[i]) begin
          grant    = '0;
          grant[i] = 1'b1;
          sel      = CH_W'(i);
        end
      end
    end
    done = '0;
    if (xfer_req && xfer_ack) done[xfer_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_req  <= 1'b0;
      xfer_ch   <= '0;
      xfer_txd  <= '0;
      xfer_bits <= '0;
    end else if (xfer_req && xfer_ack) begin
      xfer_req <= 1'b0;
    end else if (|grant) begin
      xfer_req  <= 1'b1;
      xfer_ch   <= sel;
      xfer_txd  <= tx_arr[sel];
      xfer_bits <= bits_arr[sel];
    end
  end

  p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_txd) && $stable(xfer_ch) && $stable(xfer_bits));
  p_ack_ends_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_req && xfer_ack |=> !xfer_req);
  p_single_grant_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
endmodule

// File: rtl/spi_chan_seq.sv
module spi_chan_seq
  import spi_seq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int BITS_W     = 6,
  parameter int GRP_BASE   = 'h2C,
  parameter int GRP_STRIDE = 'h14,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              single_ch,
  output logic              xfer_req,
  output logic [CH_W-1:0]   xfer_ch,
  output logic [DATA_W-1:0] xfer_txd,
  output logic [BITS_W-1:0] xfer_bits,
  input  logic              xfer_ack,
  input  logic [DATA_W-1:0] xfer_rxd,
  output logic [NUM_CH-1:0] tx_dma_req,
  output logic [NUM_CH-1:0] rx_dma_req
);
  logic [NUM_CH-1:0]             wr_conf, wr_ctrl, wr_tx, rd_rx;
  logic [NUM_CH-1:0]             want, grant, done, en_arr;
  logic [NUM_CH-1:0][DATA_W-1:0] tx_arr, rx_arr;
  logic [NUM_CH-1:0][BITS_W-1:0] bits_arr;
  logic [NUM_CH-1:0][CONF_W-1:0] conf_arr;
  chan_stat_t [NUM_CH-1:0]       stat_arr;
  logic [DATA_W-1:0]             rd_next;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int GB = GRP_BASE + g * GRP_STRIDE;
    assign wr_conf[g] = bus_wr && (bus_addr == ADDR_W'(GB + OFS_CONF));
    assign wr_ctrl[g] = bus_wr && (bus_addr == ADDR_W'(GB + OFS_CTRL));
    assign wr_tx[g]   = bus_wr && (bus_addr == ADDR_W'(GB + OFS_TX));
    assign rd_rx[g]   = bus_rd && (bus_addr == ADDR_W'(GB + OFS_RX));

    spi_chan #(.DATA_W(DATA_W), .BITS_W(BITS_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .wr_conf   (wr_conf[g]),
      .wr_ctrl   (wr_ctrl[g]),
      .wr_tx     (wr_tx[g]),
      .rd_rx     (rd_rx[g]),
      .wdata     (bus_wdata),
      .single_ch (single_ch),
      .grant     (grant[g]),
      .done      (done[g]),
      .rxd       (xfer_rxd),
      .conf_q    (conf_arr[g]),
      .stat_q    (stat_arr[g]),
      .en_q      (en_arr[g]),
      .tx_q      (tx_arr[g]),
      .rx_q      (rx_arr[g]),
      .want      (want[g]),
      .bits      (bits_arr[g]),
      .tx_dma    (tx_dma_req[g]),
      .rx_dma    (rx_dma_req[g])
    );
  end

  spi_xfer_arb #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .BITS_W(BITS_W)) u_arb (
    .clk       (clk),
    .rst       (rst),
    .want      (want),
    .tx_arr    (tx_arr),
    .bits_arr  (bits_arr),
    .xfer_ack  (xfer_ack),
    .grant     (grant),
    .done      (done),
    .xfer_req  (xfer_req),
    .xfer_ch   (xfer_ch),
    .xfer_txd  (xfer_txd),
    .xfer_bits (xfer_bits)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ADDR_W'(GRP_BASE + i * GRP_STRIDE + OFS_CONF))
        rd_next = DATA_W'(conf_arr[i]);
      if (bus_addr == ADDR_W'(GRP_BASE + i * GRP_STRIDE + OFS_STAT))
        rd_next = DATA_W'(stat_arr[i]);
      if (bus_addr == ADDR_W'(GRP_BASE + i * GRP_STRIDE + OFS_CTRL))
        rd_next = DATA_W'(en_arr[i]);
      if (bus_addr == ADDR_W'(GRP_BASE + i * GRP_STRIDE + OFS_TX))
        rd_next = tx_arr[i];
      if (bus_addr == ADDR_W'(GRP_BASE + i * GRP_STRIDE + OFS_RX))
        rd_next = rx_arr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> !xfer_req && tx_dma_req == '0 && rx_dma_req == '0);
endmodule

// File: tb/test_spi_chan_seq.sv
`timescale 1ns/1ps
module test_spi_chan_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        single_ch = 1'b0;
  logic        xfer_req;
  logic [1:0]  xfer_ch;
  logic [31:0] xfer_txd;
  logic [5:0]  xfer_bits;
  logic        xfer_ack = 1'b0;
  logic [31:0] xfer_rxd = '0;
  logic [3:0]  tx_dma_req, rx_dma_req;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  spi_chan_seq i_spi_chan_seq (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .single_ch(single_ch),
    .xfer_req(xfer_req), .xfer_ch(xfer_ch), .xfer_txd(xfer_txd), .xfer_bits(xfer_bits),
    .xfer_ack(xfer_ack), .xfer_rxd(xfer_rxd),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  localparam int R_CONF = 0, R_STAT = 1, R_CTRL = 2, R_TX = 3, R_RX = 4;

  // vector table: config, tx word, returned word, expected bits, status after exchange
  localparam logic [31:0] V_CONF [4] = '{32'h0000_0380, 32'h0000_2780, 32'h0000_0F80, 32'h0000_1180};
  localparam logic [31:0] V_TX   [4] = '{32'h0000_00A5, 32'h0000_1234, 32'hDEAD_BEEF, 32'h0000_0005};
  localparam logic [31:0] V_RX   [4] = '{32'h0000_003C, 32'h0000_0077, 32'hCAFE_F00D, 32'h0000_000A};
  localparam logic [31:0] V_BITS [4] = '{32'd8, 32'd16, 32'd32, 32'd4};
  localparam logic [31:0] V_STAT [4] = '{32'h7, 32'h6, 32'h7, 32'h7};

  function automatic logic [7:0] ra(input int ch, input int r);
    return 8'(32'h2C + ch * 32'h14 + r * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ack(input logic [31:0] d);
    xfer_ack = 1'b1; xfer_rxd = d;
    @(posedge clk); @(negedge clk);
    xfer_ack = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // the access that triggers a decision has just completed: low now, high one cycle later
  task automatic expect_req(input string tag, input int ch, input logic [31:0] txd, input logic [31:0] nb);
    chk({tag, " R13 req not yet"}, 32'(xfer_req), 32'd0);
    @(negedge clk);
    chk({tag, " R6 req"}, 32'(xfer_req), 32'd1);
    chk({tag, " R6 ch"}, 32'(xfer_ch), 32'(ch));
    chk({tag, " R6 txd"}, xfer_txd, txd);
    chk({tag, " R6 bits"}, 32'(xfer_bits), nb);
  endtask

  task automatic expect_no_req(input string tag);
    @(negedge clk);
    chk(tag, 32'(xfer_req), 32'd0);
  endtask

  initial begin
    #160000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    brd(ra(0, R_CONF), d); chk("R1 conf0", d, 32'h060000);
    brd(ra(3, R_STAT), d); chk("R1 stat3", d, 32'h2);
    brd(ra(2, R_CTRL), d); chk("R1 ctrl2", d, 32'h0);
    chk("R1 req", 32'(xfer_req), 32'd0);
    chk("R1 dma", {24'd0, tx_dma_req, rx_dma_req}, 32'd0);

    // R3 read-only words
    bwr(ra(1, R_STAT), 32'h0);
    bwr(ra(1, R_RX), 32'hFFFF_FFFF);
    brd(ra(1, R_STAT), d); chk("R3 stat", d, 32'h2);
    brd(ra(1, R_RX), d); chk("R3 rx", d, 32'h0);

    // R2 config mask
    bwr(ra(2, R_CONF), 32'hFFFF_FFFF);
    brd(ra(2, R_CONF), d); chk("R2 conf mask", d, 32'h7F_FFFF);
    do_reset();

    // table walk: one vector per channel
    for (int v = 0; v < 4; v++) begin
      bwr(ra(v, R_CONF), V_CONF[v]);
      brd(ra(v, R_CONF), d); chk("R2 conf readback", d, V_CONF[v]);
      bwr(ra(v, R_TX), V_TX[v]);
      expect_no_req("R9 disabled no start");
      brd(ra(v, R_STAT), d); chk("R4 txs cleared", d, 32'h0);
      bwr(ra(v, R_CTRL), 32'h1);
      expect_req("R9 enable start", v, V_TX[v], V_BITS[v]);
      ack(V_RX[v]);
      chk("R6 req dropped", 32'(xfer_req), 32'd0);
      brd(ra(v, R_STAT), d); chk("R7 status", d, V_STAT[v]);
      brd(ra(v, R_TX), d); chk("R7 tx cleared", d, 32'h0);
      bwr(ra(v, R_CTRL), 32'h0);
      brd(ra(v, R_RX), d); chk("R10 rx word", d, V_RX[v]);
      brd(ra(v, R_STAT), d); chk("R10 rxs cleared", d, V_STAT[v] & 32'h6);
      chk("R9 no start after disable", 32'(xfer_req), 32'd0);
    end

    // R11 DMA requests
    do_reset();
    bwr(ra(0, R_CONF), 32'h0000_C380);
    bwr(ra(0, R_CTRL), 32'h1);
    chk("R11 tx dma", 32'(tx_dma_req), 32'h1);
    chk("R11 rx dma", 32'(rx_dma_req), 32'h0);
    bwr(ra(0, R_CONF), 32'h0000_D380);
    chk("R11 tx dma rx-only", 32'(tx_dma_req), 32'h0);
    bwr(ra(0, R_CONF), 32'h0000_C380);
    bwr(ra(0, R_TX), 32'h55);
    expect_req("R11 xfer", 0, 32'h55, 32'd8);
    ack(32'h66);
    chk("R11 both dma", {28'd0, tx_dma_req[0], rx_dma_req[0]}, 32'h3);
    bwr(ra(0, R_CONF), 32'h0000_E380);
    chk("R11 rx dma tx-only", {28'd0, tx_dma_req[0], rx_dma_req[0]}, 32'h2);

    // R8 single-channel mode
    do_reset();
    single_ch = 1'b1;
    bwr(ra(2, R_CONF), 32'h0000_0380);
    bwr(ra(2, R_TX), 32'h11);
    bwr(ra(2, R_CTRL), 32'h1);
    expect_no_req("R8 skip no req");
    brd(ra(2, R_STAT), d); chk("R8 skip status", d, 32'h7);
    brd(ra(2, R_TX), d); chk("R8 skip tx cleared", d, 32'h0);
    brd(ra(2, R_RX), d); chk("R8 skip rx kept", d, 32'h0);
    bwr(ra(2, R_CONF), 32'h0010_0380);
    bwr(ra(2, R_TX), 32'h22);
    expect_req("R8 force", 2, 32'h22, 32'd8);
    ack(32'h99);
    single_ch = 1'b0;
    brd(ra(2, R_RX), d); chk("R8 force rx", d, 32'h99);

    // R5 stall on RX full, turbo bypass
    do_reset();
    bwr(ra(0, R_CONF), 32'h0000_0380);
    bwr(ra(0, R_CTRL), 32'h1);
    expect_no_req("R5 stall on txs");
    bwr(ra(0, R_TX), 32'h1);
    expect_req("R5 first", 0, 32'h1, 32'd8);
    ack(32'hA1);
    bwr(ra(0, R_TX), 32'h2);
    expect_no_req("R5 stall on rxs");
    brd(ra(0, R_STAT), d); chk("R5 stalled status", d, 32'h5);
    brd(ra(0, R_RX), d); chk("R10 rx word", d, 32'hA1);
    expect_req("R10 read restarts", 0, 32'h2, 32'd8);
    ack(32'hA2);
    bwr(ra(1, R_CONF), 32'h0008_0380);
    bwr(ra(1, R_CTRL), 32'h1);
    bwr(ra(1, R_TX), 32'h3);
    expect_req("R5 turbo first", 1, 32'h3, 32'd8);
    ack(32'hB1);
    bwr(ra(1, R_TX), 32'h4);
    expect_req("R5 turbo bypass", 1, 32'h4, 32'd8);
    ack(32'hB2);

    // R12 shared port: waiting channels, lowest index first
    do_reset();
    for (int c = 0; c < 3; c++) begin
      bwr(ra(c, R_CONF), 32'h0000_0380);
      bwr(ra(c, R_CTRL), 32'h1);
    end
    bwr(ra(1, R_TX), 32'h31);
    expect_req("R12 ch1 first", 1, 32'h31, 32'd8);
    bwr(ra(2, R_TX), 32'h32);
    bwr(ra(0, R_TX), 32'h30);
    chk("R12 held txd", xfer_txd, 32'h31);
    ack(32'h0);
    chk("R12 gap", 32'(xfer_req), 32'd0);
    @(negedge clk);
    chk("R12 lowest next", 32'(xfer_ch), 32'd0);
    chk("R12 req again", 32'(xfer_req), 32'd1);
    ack(32'h0);
    @(negedge clk);
    chk("R12 last ch", 32'(xfer_ch), 32'd2);
    chk("R12 last txd", xfer_txd, 32'h32);
    ack(32'h0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule